// File: doc/BRIEF.md
# Dual Integer / Floating-Point Register File

This block holds the architectural registers of a simple load/store RISC core. It contains two separate banks. The integer bank has 32 registers of 32 bits. The floating-point bank has 32 registers of 32 bits. Each bank has two read ports and one write port. Reads are combinational and return zero when their enable is low. Writes take effect on the rising clock edge. When a read hits the register being written in the same cycle, it returns the new value.

Integer register 0 is hardwired to zero. In the floating-point bank every register, including register 0, is ordinary storage. A precision select, `fp_dbl`, chooses how that bank is addressed for all three of its ports at once. When `fp_dbl` is 0 the bank is seen as 32 single registers. When `fp_dbl` is 1 it is seen as 16 64-bit registers, each made from an even/odd pair. The even member of a pair supplies bits 63:32 and the odd member supplies bits 31:0. A double access with an odd index is illegal. It raises `fp_illegal` and it neither reads nor writes anything. Both views share the same storage, so a value written in one view can be read in the other.

The block has no state machine. Its only sequential element is the register storage. Reset is synchronous and active low.

Top module: `dual_regfile`

## Requirements
- R1: While `rst_n` is low at a rising edge, every register in both banks is cleared to zero and no write commits; afterwards every enabled read returns zero until written.
- R2: An integer write with `int_wr_en`=1 to a nonzero index commits on the rising edge. From the next cycle on, either integer read port returns the stored value, and the two ports read independently.
- R3: Integer register 0 always reads as zero, and writes to index 0 are discarded.
- R4: Any read port whose enable is 0 outputs all zeros.
- R5: A read of the register being written in the same cycle returns the write data combinationally. In double mode this applies to each 32-bit half separately.
- R6: With `fp_dbl`=0, a floating-point write stores `fp_wr_data[31:0]` in the addressed register. A read returns that register in bits 31:0 of the read data, with bits 63:32 equal to zero.
- R7: With `fp_dbl`=1 and an even index n, a write stores `fp_wr_data[63:32]` in register n and `fp_wr_data[31:0]` in register n+1. A read returns {register n, register n+1}.
- R8: With `fp_dbl`=1, an odd index on an enabled port drives `fp_illegal` high in the same cycle. An illegal write changes no register, and an illegal read returns zero.
- R9: The single and double views alias the same storage, so data written in one view reads back in the other.
- R10: Floating-point register 0 is ordinary storage and keeps a written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low clear |
| int_rd_en_a | input | 1 | Integer read port A enable |
| int_rd_addr_a | input | 5 | Integer read port A index |
| int_rd_data_a | output | 32 | Integer read port A data |
| int_rd_en_b | input | 1 | Integer read port B enable |
| int_rd_addr_b | input | 5 | Integer read port B index |
| int_rd_data_b | output | 32 | Integer read port B data |
| int_wr_en | input | 1 | Integer write enable |
| int_wr_addr | input | 5 | Integer write index |
| int_wr_data | input | 32 | Integer write data |
| fp_dbl | input | 1 | Floating-point precision select, 1 = double pairs |
| fp_rd_en_a | input | 1 | FP read port A enable |
| fp_rd_addr_a | input | 5 | FP read port A index |
| fp_rd_data_a | output | 64 | FP read port A data |
| fp_rd_en_b | input | 1 | FP read port B enable |
| fp_rd_addr_b | input | 5 | FP read port B index |
| fp_rd_data_b | output | 64 | FP read port B data |
| fp_wr_en | input | 1 | FP write enable |
| fp_wr_addr | input | 5 | FP write index |
| fp_wr_data | input | 64 | FP write data |
| fp_illegal | output | 1 | Odd index used on an enabled port in double mode |

## Verification
The bound checker watches several properties on every cycle:
- The integer zero register reads as zero.
- Disabled ports output zero.
- Single-mode reads have a zero upper half.
- An odd double-mode index raises the illegal flag.
- Same-cycle bypass returns the write data on the integer ports.
- An integer write reads back on the following cycle.
- All reads are zero right after reset.

Some behaviour can only be shown by the bench's scenarios, because it depends on what is stored rather than on a single cycle:
- The pair ordering inside a double register.
- Aliasing between the single and double views.
- A suppressed odd-index write really leaving both neighbouring registers untouched.
- A reset taken in the middle of a run discarding the write presented with it.

// File: rtl/rf_pkg.sv
package rf_pkg;

    typedef enum logic {
        PREC_SINGLE = 1'b0,
        PREC_DOUBLE = 1'b1
    } fp_prec_e;

    localparam int unsigned READ_PORTS = 2;

endpackage

// File: rtl/rf_int_bank.sv
module rf_int_bank #(
    parameter int unsigned NREG = 32,
    parameter int unsigned W    = 32,
    parameter int unsigned NRD  = 2,
    parameter int unsigned AW   = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NRD-1:0]          rd_en,
    input  logic [NRD-1:0][AW-1:0]  rd_addr,
    output logic [NRD-1:0][W-1:0]   rd_data,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [W-1:0]            wr_data
);

    logic [W-1:0] regs [NREG];
    logic         wr_go;

    // Writes to the zero register and writes during reset never commit.
    assign wr_go = wr_en && (wr_addr != '0) && rst_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) begin
                regs[i] <= '0;
            end
        end else if (wr_go) begin
            regs[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        always_comb begin
            if (!rd_en[p] || (rd_addr[p] == '0)) begin
                rd_data[p] = '0;
            end else if (wr_go && (wr_addr == rd_addr[p])) begin
                rd_data[p] = wr_data;
            end else begin
                rd_data[p] = regs[rd_addr[p]];
            end
        end
    end

endmodule

// File: rtl/rf_fp_bank.sv
module rf_fp_bank
    import rf_pkg::*;
#(
    parameter int unsigned NREG = 32,
    parameter int unsigned W    = 32,
    parameter int unsigned NRD  = 2,
    parameter int unsigned AW   = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  fp_prec_e                 prec,
    input  logic [NRD-1:0]           rd_en,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][2*W-1:0]  rd_data,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [2*W-1:0]           wr_data,
    output logic                     illegal
);

    localparam int unsigned DW = 2 * W;

    logic [W-1:0]   regs [NREG];
    logic           dbl;
    logic [NRD-1:0] rd_bad;
    logic           wr_bad;

    // Two word lanes: lane 0 is the addressed word, lane 1 the odd partner.
    logic           l0_en, l1_en;
    logic [AW-1:0]  l0_idx, l1_idx;
    logic [W-1:0]   l0_val, l1_val;

    assign dbl     = (prec == PREC_DOUBLE);
    assign wr_bad  = dbl && wr_en && wr_addr[0];
    assign illegal = (|rd_bad) || wr_bad;

    assign l0_en  = wr_en && !wr_bad && rst_n;
    assign l0_idx = wr_addr;
    assign l0_val = dbl ? wr_data[DW-1:W] : wr_data[W-1:0];
    assign l1_en  = wr_en && dbl && !wr_addr[0] && rst_n;
    assign l1_idx = {wr_addr[AW-1:1], 1'b1};
    assign l1_val = wr_data[W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(NREG); i++) begin
                regs[i] <= '0;
            end
        end else begin
            if (l0_en) regs[l0_idx] <= l0_val;
            if (l1_en) regs[l1_idx] <= l1_val;
        end
    end

    function automatic logic [W-1:0] fetch_word(input logic [AW-1:0] idx);
        if (l1_en && (idx == l1_idx)) begin
            return l1_val;
        end else if (l0_en && (idx == l0_idx)) begin
            return l0_val;
        end
        return regs[idx];
    endfunction

    for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
        logic [AW-1:0] odd_idx;
        assign rd_bad[p] = dbl && rd_en[p] && rd_addr[p][0];
        assign odd_idx   = {rd_addr[p][AW-1:1], 1'b1};

        always_comb begin
            if (!rd_en[p] || rd_bad[p]) begin
                rd_data[p] = '0;
            end else if (dbl) begin
                rd_data[p] = {fetch_word(rd_addr[p]), fetch_word(odd_idx)};
            end else begin
                rd_data[p] = {{W{1'b0}}, fetch_word(rd_addr[p])};
            end
        end
    end

endmodule

// File: rtl/dual_regfile.sv
module dual_regfile
    import rf_pkg::*;
#(
    parameter int unsigned INT_REGS = 32,
    parameter int unsigned FP_REGS  = 32,
    parameter int unsigned XLEN     = 32,
    parameter int unsigned IA_W     = $clog2(INT_REGS),
    parameter int unsigned FA_W     = $clog2(FP_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_rd_en_a,
    input  logic [IA_W-1:0]   int_rd_addr_a,
    output logic [XLEN-1:0]   int_rd_data_a,
    input  logic              int_rd_en_b,
    input  logic [IA_W-1:0]   int_rd_addr_b,
    output logic [XLEN-1:0]   int_rd_data_b,
    input  logic              int_wr_en,
    input  logic [IA_W-1:0]   int_wr_addr,
    input  logic [XLEN-1:0]   int_wr_data,
    input  logic              fp_dbl,
    input  logic              fp_rd_en_a,
    input  logic [FA_W-1:0]   fp_rd_addr_a,
    output logic [2*XLEN-1:0] fp_rd_data_a,
    input  logic              fp_rd_en_b,
    input  logic [FA_W-1:0]   fp_rd_addr_b,
    output logic [2*XLEN-1:0] fp_rd_data_b,
    input  logic              fp_wr_en,
    input  logic [FA_W-1:0]   fp_wr_addr,
    input  logic [2*XLEN-1:0] fp_wr_data,
    output logic              fp_illegal
);

    localparam int unsigned NRD = READ_PORTS;

    logic [NRD-1:0]             i_en;
    logic [NRD-1:0][IA_W-1:0]   i_addr;
    logic [NRD-1:0][XLEN-1:0]   i_data;
    logic [NRD-1:0]             f_en;
    logic [NRD-1:0][FA_W-1:0]   f_addr;
    logic [NRD-1:0][2*XLEN-1:0] f_data;
    fp_prec_e                   f_prec;

    assign i_en   = {int_rd_en_b, int_rd_en_a};
    assign i_addr = {int_rd_addr_b, int_rd_addr_a};
    assign int_rd_data_a = i_data[0];
    assign int_rd_data_b = i_data[1];

    assign f_en   = {fp_rd_en_b, fp_rd_en_a};
    assign f_addr = {fp_rd_addr_b, fp_rd_addr_a};
    assign fp_rd_data_a = f_data[0];
    assign fp_rd_data_b = f_data[1];
    assign f_prec = fp_dbl ? PREC_DOUBLE : PREC_SINGLE;

    rf_int_bank #(
        .NREG (INT_REGS),
        .W    (XLEN),
        .NRD  (NRD),
        .AW   (IA_W)
    ) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (i_en),
        .rd_addr (i_addr),
        .rd_data (i_data),
        .wr_en   (int_wr_en),
        .wr_addr (int_wr_addr),
        .wr_data (int_wr_data)
    );

    rf_fp_bank #(
        .NREG (FP_REGS),
        .W    (XLEN),
        .NRD  (NRD),
        .AW   (FA_W)
    ) u_fp (
        .clk     (clk),
        .rst_n   (rst_n),
        .prec    (f_prec),
        .rd_en   (f_en),
        .rd_addr (f_addr),
        .rd_data (f_data),
        .wr_en   (fp_wr_en),
        .wr_addr (fp_wr_addr),
        .wr_data (fp_wr_data),
        .illegal (fp_illegal)
    );

endmodule

// File: rtl/rf_checker.sv
module rf_checker #(
    parameter int unsigned XLEN = 32,
    parameter int unsigned IA_W = 5,
    parameter int unsigned FA_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              int_rd_en_a,
    input logic [IA_W-1:0]   int_rd_addr_a,
    input logic [XLEN-1:0]   int_rd_data_a,
    input logic              int_rd_en_b,
    input logic [XLEN-1:0]   int_rd_data_b,
    input logic              int_wr_en,
    input logic [IA_W-1:0]   int_wr_addr,
    input logic [XLEN-1:0]   int_wr_data,
    input logic              fp_dbl,
    input logic              fp_rd_en_a,
    input logic [2*XLEN-1:0] fp_rd_data_a,
    input logic              fp_rd_en_b,
    input logic [2*XLEN-1:0] fp_rd_data_b,
    input logic              fp_wr_en,
    input logic [FA_W-1:0]   fp_wr_addr,
    input logic              fp_illegal
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && !int_wr_en && !fp_wr_en) |->
            (int_rd_data_a == '0 && int_rd_data_b == '0 &&
             fp_rd_data_a == '0 && fp_rd_data_b == '0));

    assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(int_wr_en) && $past(int_wr_addr) != '0 &&
         int_rd_en_a && int_rd_addr_a == $past(int_wr_addr) && !int_wr_en) |->
            int_rd_data_a == $past(int_wr_data));

    assert_zero_reg_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int_rd_addr_a == '0) |-> int_rd_data_a == '0);

    assert_disabled_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!int_rd_en_a || !int_rd_en_b || !fp_rd_en_a || !fp_rd_en_b) |->
            ((int_rd_en_a || int_rd_data_a == '0) &&
             (int_rd_en_b || int_rd_data_b == '0) &&
             (fp_rd_en_a  || fp_rd_data_a  == '0) &&
             (fp_rd_en_b  || fp_rd_data_b  == '0)));

    assert_bypass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wr_en && int_wr_addr != '0 && int_rd_en_a &&
         int_rd_addr_a == int_wr_addr) |-> int_rd_data_a == int_wr_data);

    assert_single_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_dbl |-> (fp_rd_data_a[2*XLEN-1:XLEN] == '0 &&
                     fp_rd_data_b[2*XLEN-1:XLEN] == '0));

    assert_odd_write_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_dbl && fp_wr_en && fp_wr_addr[0]) |-> fp_illegal);

    assert_single_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !fp_dbl |-> !fp_illegal);

endmodule

bind dual_regfile rf_checker #(
    .XLEN (XLEN),
    .IA_W (IA_W),
    .FA_W (FA_W)
) u_rf_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .int_rd_en_a   (int_rd_en_a),
    .int_rd_addr_a (int_rd_addr_a),
    .int_rd_data_a (int_rd_data_a),
    .int_rd_en_b   (int_rd_en_b),
    .int_rd_data_b (int_rd_data_b),
    .int_wr_en     (int_wr_en),
    .int_wr_addr   (int_wr_addr),
    .int_wr_data   (int_wr_data),
    .fp_dbl        (fp_dbl),
    .fp_rd_en_a    (fp_rd_en_a),
    .fp_rd_data_a  (fp_rd_data_a),
    .fp_rd_en_b    (fp_rd_en_b),
    .fp_rd_data_b  (fp_rd_data_b),
    .fp_wr_en      (fp_wr_en),
    .fp_wr_addr    (fp_wr_addr),
    .fp_illegal    (fp_illegal)
);

// File: tb/tb_dual_regfile.sv
module tb_dual_regfile;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        int_rd_en_a, int_rd_en_b, int_wr_en;
    logic [4:0]  int_rd_addr_a, int_rd_addr_b, int_wr_addr;
    logic [31:0] int_rd_data_a, int_rd_data_b, int_wr_data;
    logic        fp_dbl, fp_rd_en_a, fp_rd_en_b, fp_wr_en, fp_illegal;
    logic [4:0]  fp_rd_addr_a, fp_rd_addr_b, fp_wr_addr;
    logic [63:0] fp_rd_data_a, fp_rd_data_b, fp_wr_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dual_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .int_rd_en_a(int_rd_en_a), .int_rd_addr_a(int_rd_addr_a), .int_rd_data_a(int_rd_data_a),
        .int_rd_en_b(int_rd_en_b), .int_rd_addr_b(int_rd_addr_b), .int_rd_data_b(int_rd_data_b),
        .int_wr_en(int_wr_en), .int_wr_addr(int_wr_addr), .int_wr_data(int_wr_data),
        .fp_dbl(fp_dbl),
        .fp_rd_en_a(fp_rd_en_a), .fp_rd_addr_a(fp_rd_addr_a), .fp_rd_data_a(fp_rd_data_a),
        .fp_rd_en_b(fp_rd_en_b), .fp_rd_addr_b(fp_rd_addr_b), .fp_rd_data_b(fp_rd_data_b),
        .fp_wr_en(fp_wr_en), .fp_wr_addr(fp_wr_addr), .fp_wr_data(fp_wr_data),
        .fp_illegal(fp_illegal)
    );

    // Integer vectors: {wr_en, wr_addr, wr_data, rd_addr_a, expected_a}
    localparam int NVEC = 9;
    localparam logic [74:0] VEC [NVEC] = '{
        {1'b1, 5'd5,  32'h1111_1111, 5'd5,  32'h1111_1111},  // R5 bypass
        {1'b1, 5'd6,  32'h2222_2222, 5'd5,  32'h1111_1111},  // R2 stored
        {1'b1, 5'd0,  32'hDEAD_BEEF, 5'd0,  32'h0000_0000},  // R3 write r0
        {1'b0, 5'd0,  32'h0000_0000, 5'd0,  32'h0000_0000},  // R3 r0 still zero
        {1'b1, 5'd31, 32'hFFFF_FFFF, 5'd6,  32'h2222_2222},  // R2
        {1'b0, 5'd0,  32'h0000_0000, 5'd31, 32'hFFFF_FFFF},  // R2 top index
        {1'b1, 5'd5,  32'hA5A5_A5A5, 5'd5,  32'hA5A5_A5A5},  // R5 overwrite bypass
        {1'b0, 5'd0,  32'h0000_0000, 5'd5,  32'hA5A5_A5A5},  // R2 overwrite held
        {1'b0, 5'd0,  32'h0000_0000, 5'd7,  32'h0000_0000}   // R1 untouched
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        int_rd_en_a = 0; int_rd_en_b = 0; int_wr_en = 0;
        int_rd_addr_a = 0; int_rd_addr_b = 0; int_wr_addr = 0; int_wr_data = 0;
        fp_dbl = 0; fp_rd_en_a = 0; fp_rd_en_b = 0; fp_wr_en = 0;
        fp_rd_addr_a = 0; fp_rd_addr_b = 0; fp_wr_addr = 0; fp_wr_data = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        int_rd_en_a = 1; int_rd_addr_a = 5'd9;
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd3;
        #1;
        check("R1 int reset", {32'd0, int_rd_data_a}, 64'd0);
        check("R1 fp reset", fp_rd_data_a, 64'd0);

        // Vector table, integer bank port A
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            idle();
            int_wr_en     = VEC[i][74];
            int_wr_addr   = VEC[i][73:69];
            int_wr_data   = VEC[i][68:37];
            int_rd_en_a   = 1'b1;
            int_rd_addr_a = VEC[i][36:32];
            #1;
            check("R2/R3/R5 vector", {32'd0, int_rd_data_a}, {32'd0, VEC[i][31:0]});
        end

        // R2 port B independent of A
        @(negedge clk); idle();
        int_rd_en_a = 1; int_rd_addr_a = 5'd6;
        int_rd_en_b = 1; int_rd_addr_b = 5'd31;
        #1;
        check("R2 port A", {32'd0, int_rd_data_a}, 64'h2222_2222);
        check("R2 port B", {32'd0, int_rd_data_b}, 64'hFFFF_FFFF);

        // R4 disabled ports read zero
        @(negedge clk); idle();
        int_rd_addr_a = 5'd6; fp_rd_addr_a = 5'd0;
        #1;
        check("R4 int disabled", {32'd0, int_rd_data_a}, 64'd0);
        check("R4 fp disabled", fp_rd_data_a, 64'd0);

        // R6 single write / read
        @(negedge clk); idle();
        fp_wr_en = 1; fp_wr_addr = 5'd1; fp_wr_data = 64'hCAFE_0000_3F80_0000;
        @(negedge clk); idle();
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd1;
        #1;
        check("R6 single read", fp_rd_data_a, 64'h0000_0000_3F80_0000);

        // R7 double write to even pair, R9 read through single view
        @(negedge clk); idle();
        fp_dbl = 1; fp_wr_en = 1; fp_wr_addr = 5'd4; fp_wr_data = 64'h0123_4567_89AB_CDEF;
        @(negedge clk); idle();
        fp_dbl = 1; fp_rd_en_a = 1; fp_rd_addr_a = 5'd4;
        #1;
        check("R7 double read", fp_rd_data_a, 64'h0123_4567_89AB_CDEF);
        @(negedge clk); idle();
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd4; fp_rd_en_b = 1; fp_rd_addr_b = 5'd5;
        #1;
        check("R9 even half single", fp_rd_data_a, 64'h0000_0000_0123_4567);
        check("R9 odd half single", fp_rd_data_b, 64'h0000_0000_89AB_CDEF);

        // R9 single writes seen as a double pair
        @(negedge clk); idle();
        fp_wr_en = 1; fp_wr_addr = 5'd5; fp_wr_data = 64'h0000_0000_7777_7777;
        @(negedge clk); idle();
        fp_dbl = 1; fp_rd_en_b = 1; fp_rd_addr_b = 5'd4;
        #1;
        check("R9 double after single", fp_rd_data_b, 64'h0123_4567_7777_7777);

        // R8 odd double write flagged and suppressed
        @(negedge clk); idle();
        fp_dbl = 1; fp_wr_en = 1; fp_wr_addr = 5'd5; fp_wr_data = 64'hBAD0_BAD0_BAD0_BAD0;
        #1;
        check("R8 write flag", {63'd0, fp_illegal}, 64'd1);
        @(negedge clk); idle();
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd5; fp_rd_en_b = 1; fp_rd_addr_b = 5'd6;
        #1;
        check("R8 odd reg unchanged", fp_rd_data_a, 64'h0000_0000_7777_7777);
        check("R8 next reg unchanged", fp_rd_data_b, 64'd0);
        check("R8 no flag single", {63'd0, fp_illegal}, 64'd0);

        // R8 odd double read
        @(negedge clk); idle();
        fp_dbl = 1; fp_rd_en_a = 1; fp_rd_addr_a = 5'd5;
        #1;
        check("R8 read flag", {63'd0, fp_illegal}, 64'd1);
        check("R8 read zero", fp_rd_data_a, 64'd0);

        // R10 fp register 0 is ordinary
        @(negedge clk); idle();
        fp_wr_en = 1; fp_wr_addr = 5'd0; fp_wr_data = 64'h0000_0000_0000_0055;
        @(negedge clk); idle();
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd0;
        #1;
        check("R10 fp r0 holds", fp_rd_data_a, 64'h55);

        // R5 fp bypass per half in double mode
        @(negedge clk); idle();
        fp_dbl = 1; fp_wr_en = 1; fp_wr_addr = 5'd10; fp_wr_data = 64'h1357_9BDF_2468_ACE0;
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd10;
        #1;
        check("R5 fp double bypass", fp_rd_data_a, 64'h1357_9BDF_2468_ACE0);
        @(negedge clk); idle();
        fp_wr_en = 1; fp_wr_addr = 5'd11; fp_wr_data = 64'h0000_0000_0F0F_0F0F;
        fp_rd_en_a = 1; fp_rd_addr_a = 5'd11;
        #1;
        check("R5 fp single bypass", fp_rd_data_a, 64'h0000_0000_0F0F_0F0F);

        // R1 reset mid-run clears and drops concurrent write
        @(negedge clk); idle();
        rst_n = 1'b0; int_wr_en = 1; int_wr_addr = 5'd9; int_wr_data = 32'h9999_9999;
        @(negedge clk); idle();
        rst_n = 1'b1;
        int_rd_en_a = 1; int_rd_addr_a = 5'd5; int_rd_en_b = 1; int_rd_addr_b = 5'd9;
        fp_dbl = 1; fp_rd_en_a = 1; fp_rd_addr_a = 5'd4;
        #1;
        check("R1 int cleared", {32'd0, int_rd_data_a}, 64'd0);
        check("R1 write in reset dropped", {32'd0, int_rd_data_b}, 64'd0);
        check("R1 fp cleared", fp_rd_data_a, 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule